// File: doc/BRIEF.md
# Clock Synthesizer Divider Configuration Port

This block keeps the settings that a frequency synthesizer needs: the 9-bit feedback (loop) divide value, a 2-bit code that selects a power-of-two output divide, and a 3-bit test-mode field. Those settings can come from a parallel pin bus or from a three-wire serial port. The serial port has a clock, a data line and a load strobe. It shifts a 14-bit word into a shift register. The oscillator, the phase-locked loop and the output drivers live elsewhere. This block only presents the codes that steer them.

All four strobe and data inputs are brought into a single system clock through synchronizer stages. That clock runs at least four times faster than the serial clock. Edges are found in that domain, and every register changes on a system clock edge.

In parallel mode the pin values flow through to the settings, and they are frozen when the parallel strobe returns high. In serial mode the settings follow the shift register for as long as the serial load strobe is high, and they freeze when that strobe falls. The parallel path takes precedence over the serial path. The oldest shift-register bit is driven out so that several ports can be chained. A flag reports a feedback value that lies outside the lock range set by parameters.

Top module: `synth_cfg_top`

## Requirements
- R1: After reset the feedback value is 511 (all ones), the output-divide code is 11 (factor 8), the test field is 000, the shift register is zero and the serial tap is 0.
- R2: While parLoadN is high, each rising edge of serClk shifts serData into the 14-bit register at bit 0. The first bit of a word therefore ends in bit 13. The word order is test[2:0], then divide code[1:0], then feedback[8:0], each field MSB first.
- R3: When serLoad rises while parLoadN is high, the shift register is copied into the settings: feedback from bits 8:0, divide code from bits 10:9 and test field from bits 13:11. A serial clock edge in the same synchronized cycle as that rise is part of the loaded word.
- R4: While serLoad stays high, every further serial shift reaches the feedback value with no additional strobe.
- R5: After serLoad falls, further shifting leaves the settings unchanged. A serial clock edge in the same synchronized cycle as that fall is not loaded.
- R6: While parLoadN is low, the feedback value and divide code follow parM and parN, the test field is forced to 000, and serial clock edges do not shift.
- R7: After parLoadN rises, changes on parM and parN are ignored until the next parallel or serial load.
- R8: With parLoadN low, a high serLoad does not take the settings away from the pins.
- R9: nFactor is one-hot: code 00 gives 1, code 01 gives 2, code 10 gives 4 and code 11 gives 8.
- R10: testSelOh has exactly one bit set, at the index equal to the test field.
- R11: mOutOfRange is high exactly when the feedback value is below LockMin (default 250) or above LockMax (default 511).
- R12: shiftOut carries bit 13 of the shift register, which is the oldest bit shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial shift clock |
| serData | input | 1 | Serial data, taken on rising serClk |
| serLoad | input | 1 | Serial load strobe; high is transparent, falling edge freezes |
| parLoadN | input | 1 | Parallel strobe; low is transparent, rising edge freezes |
| parM | input | 9 | Parallel feedback value |
| parN | input | 2 | Parallel output-divide code |
| mActive | output | 9 | Active feedback divide value |
| nFactor | output | 4 | One-hot output divide factor |
| testMode | output | 3 | Active test field |
| testSelOh | output | 8 | One-hot selector for the test output source |
| shiftOut | output | 1 | Oldest shift-register bit, for chaining |
| mOutOfRange | output | 1 | Feedback value lies outside the lock range |

## Verification
Two things can land in the same synchronized cycle: a serial shift and a change of the serial load level. The bench raises serClk and serLoad in the same time step, so both reach the control logic in one cycle. It expects the bit from that edge to be part of the loaded feedback value. It then drops serLoad together with another serClk rise. In that case it expects the settings to keep the value they had before that edge, while shiftOut shows that the shift itself still happened.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

  // Strobes passed from the control module to the datapath, one system cycle each
  typedef struct packed {
    logic shiftEn;  // a synchronized rising serial clock edge in serial mode
    logic parXfer;  // parallel mode: copy pins into the settings
    logic serXfer;  // serial load high: copy the shift register into the settings
    logic serBit;   // synchronized serial data bit
  } cfg_ctl_t;

endpackage

// File: rtl/synth_cfg_ctrl.sv
module synth_cfg_ctrl
  import synth_cfg_pkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     serClk,
  input  logic     serData,
  input  logic     serLoad,
  input  logic     parLoadN,
  output cfg_ctl_t ctl
);

  localparam int NumIn = 4;
  // Bit order is {parLoadN, serLoad, serData, serClk}; parLoadN idles high
  localparam logic [NumIn-1:0] IdleVec = 4'b1000;

  logic [NumIn-1:0] rawVec;
  logic [NumIn-1:0] syncPipe [SyncStages];
  logic [NumIn-1:0] syncVec;
  logic             serClkPrev;
  logic             serClkS, serDataS, serLoadS, parLoadNs;

  assign rawVec = {parLoadN, serLoad, serData, serClk};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SyncStages; s++) syncPipe[s] <= IdleVec;
    end else begin
      syncPipe[0] <= rawVec;
      for (int s = 1; s < SyncStages; s++) syncPipe[s] <= syncPipe[s-1];
    end
  end

  assign syncVec   = syncPipe[SyncStages-1];
  assign serClkS   = syncVec[0];
  assign serDataS  = syncVec[1];
  assign serLoadS  = syncVec[2];
  assign parLoadNs = syncVec[3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) serClkPrev <= 1'b0;
    else       serClkPrev <= serClkS;
  end

  // The parallel path takes precedence: while its strobe is low, nothing serial happens
  always_comb begin
    ctl.shiftEn = serClkS & ~serClkPrev & parLoadNs;
    ctl.parXfer = ~parLoadNs;
    ctl.serXfer = parLoadNs & serLoadS;
    ctl.serBit  = serDataS;
  end

  // R2: a single serial clock edge yields exactly one shift strobe
  a_r2_single_shift: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shiftEn |=> !ctl.shiftEn);

  // R8: the parallel path never grants the serial path in the same cycle
  a_r8_par_wins: assert property (@(posedge clk) disable iff (!rstN)
    ctl.parXfer |-> (!ctl.serXfer && !ctl.shiftEn));

endmodule

// File: rtl/synth_cfg_data.sv
module synth_cfg_data
  import synth_cfg_pkg::*;
#(
  parameter int MW = 9,
  parameter int NW = 2,
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  cfg_ctl_t      ctl,
  input  logic [MW-1:0] parM,
  input  logic [NW-1:0] parN,
  output logic [MW-1:0] mReg,
  output logic [NW-1:0] nReg,
  output logic [TW-1:0] tReg,
  output logic          shiftOut
);

  localparam int SW = TW + NW + MW;

  logic [SW-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            shiftReg <= '0;
    else if (ctl.shiftEn) shiftReg <= {shiftReg[SW-2:0], ctl.serBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mReg <= '1;
      nReg <= '1;
      tReg <= '0;
    end else if (ctl.parXfer) begin
      mReg <= parM;
      nReg <= parN;
      tReg <= '0;
    end else if (ctl.serXfer) begin
      mReg <= shiftReg[MW-1:0];
      nReg <= shiftReg[MW+NW-1:MW];
      tReg <= shiftReg[SW-1:MW+NW];
    end
  end

  assign shiftOut = shiftReg[SW-1];

  // R6: in parallel mode the pins reach the settings one cycle later, test forced to 0
  a_r6_par_follow: assert property (@(posedge clk) disable iff (!rstN)
    ctl.parXfer |=> (mReg == $past(parM) && nReg == $past(parN) && tReg == '0));

  // R4: serial transparency carries the shift register into the feedback value
  a_r4_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.serXfer && !ctl.parXfer) |=> mReg == $past(shiftReg[MW-1:0]));

  // R5 and R7: with no transfer strobe the settings hold
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.serXfer && !ctl.parXfer) |=> ($stable(mReg) && $stable(nReg) && $stable(tReg)));

  // R12: the tap advances by one position on every shift
  a_r12_tap_moves: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shiftEn |=> shiftOut == $past(shiftReg[SW-2]));

  // R2: no shift strobe, no change in the register
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.shiftEn |=> $stable(shiftReg));

endmodule

// File: rtl/synth_cfg_top.sv
module synth_cfg_top
  import synth_cfg_pkg::*;
#(
  parameter int MW         = 9,
  parameter int NW         = 2,
  parameter int TW         = 3,
  parameter int SyncStages = 2,
  parameter int LockMin    = 250,
  parameter int LockMax    = 511,
  localparam int FW        = 1 << NW,
  localparam int SelW      = 1 << TW
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            serClk,
  input  logic            serData,
  input  logic            serLoad,
  input  logic            parLoadN,
  input  logic [MW-1:0]   parM,
  input  logic [NW-1:0]   parN,
  output logic [MW-1:0]   mActive,
  output logic [FW-1:0]   nFactor,
  output logic [TW-1:0]   testMode,
  output logic [SelW-1:0] testSelOh,
  output logic            shiftOut,
  output logic            mOutOfRange
);

  localparam logic [MW:0] LoLimit = (MW+1)'(LockMin);
  localparam logic [MW:0] HiLimit = (MW+1)'(LockMax);

  cfg_ctl_t      ctl;
  logic [NW-1:0] nReg;

  synth_cfg_ctrl #(.SyncStages(SyncStages)) u_ctrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serLoad(serLoad), .parLoadN(parLoadN), .ctl(ctl)
  );

  synth_cfg_data #(.MW(MW), .NW(NW), .TW(TW)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .parM(parM), .parN(parN),
    .mReg(mActive), .nReg(nReg), .tReg(testMode), .shiftOut(shiftOut)
  );

  always_comb begin
    nFactor = '0;
    nFactor[nReg] = 1'b1;
    testSelOh = '0;
    testSelOh[testMode] = 1'b1;
  end

  assign mOutOfRange = ({1'b0, mActive} < LoLimit) || ({1'b0, mActive} > HiLimit);

  // R9: exactly one divide factor is selected
  a_r9_factor_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $countones(nFactor) == 1);

  // R10: exactly one test source is selected
  a_r10_sel_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $countones(testSelOh) == 1);

endmodule

// File: tb/tb_synth_cfg_top.sv
`timescale 1ns/1ps
module tb_synth_cfg_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       serClk, serData, serLoad, parLoadN;
  logic [8:0] parM;
  logic [1:0] parN;
  logic [8:0] mActive;
  logic [3:0] nFactor;
  logic [2:0] testMode;
  logic [7:0] testSelOh;
  logic       shiftOut, mOutOfRange;

  int   nChecks = 0;
  int   nFails  = 0;
  bit   done    = 1'b0;
  logic [13:0] sr = '0;   // bench model of the shift register

  always #5 clk = ~clk;

  synth_cfg_top dut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serLoad(serLoad), .parLoadN(parLoadN), .parM(parM), .parN(parN),
    .mActive(mActive), .nFactor(nFactor), .testMode(testMode),
    .testSelOh(testSelOh), .shiftOut(shiftOut), .mOutOfRange(mOutOfRange)
  );

  typedef struct packed {
    logic [2:0] t;
    logic [1:0] n;
    logic [8:0] m;
    logic [3:0] fac;
    logic       oor;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{3'd2, 2'd1, 9'd300, 4'd2, 1'b0},
    '{3'd7, 2'd3, 9'd511, 4'd8, 1'b0},
    '{3'd0, 2'd0, 9'd100, 4'd1, 1'b1},
    '{3'd5, 2'd2, 9'd250, 4'd4, 1'b0},
    '{3'd3, 2'd1, 9'd249, 4'd2, 1'b1}
  };

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic shiftBit(logic b);
    serData = b;
    tick(4);
    serClk = 1'b1;
    sr = {sr[12:0], b};
    tick(4);
    serClk = 1'b0;
  endtask

  task automatic shiftWord(logic [13:0] w);
    for (int i = 13; i >= 0; i--) shiftBit(w[i]);
  endtask

  task automatic pulseLoad();
    serLoad = 1'b1;
    tick(6);
    serLoad = 1'b0;
    tick(6);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [8:0]  mHold;
    logic [13:0] srSave;
    logic        tapSave;
    rstN = 1'b0; serClk = 0; serData = 0; serLoad = 0; parLoadN = 1;
    parM = '0; parN = '0;
    tick(3);
    rstN = 1'b1;
    tick(2);
    // R1 reset state
    chk("R1 m", mActive, 511);
    chk("R1 factor", nFactor, 8);
    chk("R1 test", testSelOh, 1);
    chk("R1 tap", shiftOut, 0);
    chk("R11 reset range", mOutOfRange, 0);

    // Table walk: R2, R3, R9, R10, R11, R12
    for (int v = 0; v < NV; v++) begin
      shiftWord({VECS[v].t, VECS[v].n, VECS[v].m});
      pulseLoad();
      chk("R3 m", mActive, VECS[v].m);
      chk("R3 test", testMode, VECS[v].t);
      chk("R9 factor", nFactor, VECS[v].fac);
      chk("R10 sel", testSelOh, 8'd1 << VECS[v].t);
      chk("R11 flag", mOutOfRange, VECS[v].oor);
      chk("R12 tap", shiftOut, VECS[v].t[2]);
    end

    // R12 chaining and R5 latch hold
    shiftBit(1'b0);
    chk("R12 tap after shift", shiftOut, sr[13]);
    chk("R5 latched", mActive, 249);

    // R4 bypass while serLoad stays high
    serLoad = 1'b1;
    tick(6);
    chk("R4 follow", mActive, sr[8:0]);
    shiftBit(1'b1);
    tick(2);
    chk("R4 new bit", mActive, sr[8:0]);
    serLoad = 1'b0;
    tick(6);
    mHold = mActive;
    shiftBit(1'b0);
    shiftBit(1'b1);
    chk("R5 frozen", mActive, mHold);

    // Same-cycle shift and load rise: the bit is included (R3)
    serData = 1'b1;
    tick(4);
    serClk = 1'b1; serLoad = 1'b1;
    sr = {sr[12:0], 1'b1};
    tick(6);
    chk("R3 race rise", mActive, sr[8:0]);
    serClk = 1'b0;
    tick(4);
    // Same-cycle shift and load fall: the bit is excluded (R5)
    serData = 1'b0;
    tick(4);
    mHold = sr[8:0];
    serClk = 1'b1; serLoad = 1'b0;
    sr = {sr[12:0], 1'b0};
    tick(6);
    chk("R5 race fall", mActive, mHold);
    chk("R12 race tap", shiftOut, sr[13]);
    serClk = 1'b0;
    tick(4);

    // R6 parallel transparency, serial blocked
    parM = 9'd123; parN = 2'd2; parLoadN = 1'b0;
    tick(6);
    chk("R6 m", mActive, 123);
    chk("R6 factor", nFactor, 4);
    chk("R6 test forced", testMode, 0);
    srSave = sr; tapSave = shiftOut;
    shiftBit(~shiftOut);
    shiftBit(~shiftOut);
    sr = srSave;
    chk("R6 no shift", shiftOut, tapSave);
    parM = 9'd400;
    tick(4);
    chk("R6 follow", mActive, 400);

    // R8 pins win over serial load
    serLoad = 1'b1;
    tick(6);
    chk("R8 pins kept", mActive, 400);
    parM = 9'd401;
    tick(4);
    chk("R8 still pins", mActive, 401);
    serLoad = 1'b0;
    tick(6);

    // R7 parallel latch
    parLoadN = 1'b1;
    tick(6);
    parM = 9'd5; parN = 2'd0;
    tick(6);
    chk("R7 m held", mActive, 401);
    chk("R7 factor held", nFactor, 4);
    pulseLoad();
    chk("R7 serial replaces", mActive, sr[8:0]);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule